// File: doc/BRIEF.md
# Flash Array March Self-Test Controller

This block runs a March-style self-test on a NOR-type flash array that supports only three operations: a mass erase that sets every bit to one, a program that can only clear bits, and a read. A write of a one to a single cell is never issued. The test builds each pass from these operations. It reads the erased state, programs zero, and reads back, walking the addresses in ascending order in one half and descending order in the other. It can then add optional word-oriented passes. Each of those passes programs a data background or its complement over the whole array and reads it back.

Every command goes to the array through a request/ready handshake. After an erase or a program the controller also waits out a configurable penalty time. A terminal-count timer limits every wait on the array, and an expired timer is reported as a failure. Configuration picks an address scrambling, a data scrambling, or both, between the logical and physical layout. The first failing read stops the test and captures where it failed and what was seen. A clean run ends with a pass verdict.

Top module: `fmbist_ctrl`

## Requirements
- R1: A one-cycle `start` while the controller is idle or finished clears `done`, `pass`, `fail` and `fail_tmo`, captures the three configuration inputs, and begins the test. A `start` while a test is running has no effect on the command stream. After reset, `done`, `pass`, `fail` and `arr_req` are low.
- R2: Each command is a one-cycle `arr_req` pulse carrying `arr_op` = 2'b01 for mass erase, 2'b10 for program and 2'b11 for read (2'b00 when no request is made). The array lowers `arr_ready` in the cycle after the request and raises it when the operation is finished. Read data is taken when `arr_ready` is seen high.
- R3: The bit-oriented sequence is, in element order 0 to 5: erase; ascending {read all-ones, program all-zero, read all-zero} per address; ascending read all-zero; erase; descending {read all-ones, program all-zero, read all-zero}; ascending read all-zero. This makes exactly 2 erases, 2N programs and 6N reads for N words.
- R4: The descending element starts at address N-1 and ends at address 0.
- R5: With background passes enabled (W-bit word), the solid sequence is followed, for k = 0 to log2(W)-1, by one pass with pattern P_k (bit i = NOT bit k of i; 0101 and 0011 for W=4) and one with its complement. Each pass is 3 elements: erase, ascending program, ascending read and compare. Element numbering continues at 6 + 3*pass + step. The totals become 2+2log2(W) erases, (2+2log2(W))N programs and (6+2log2(W))N reads.
- R6: No address is programmed twice between two erases.
- R7: With address scrambling selected, the physical address is a XOR (a >> 1) of the logical address a. Erase commands carry address 0.
- R8: With data scrambling selected, write data and read data are bit-reversed between the logical and physical word.
- R9: If `arr_ready` is not seen within the operation's timeout limit after a request, the test ends with `fail`, `fail_tmo` and `done` high and the element and address of the hung operation captured.
- R10: After an erase (program) completes, at least ERASE_PEN (PROG_PEN) cycles pass before the next request.
- R11: On the first read whose logical data differ from the expected word, the controller captures the logical address, expected word, read word and element index, raises `fail` and `done`, and issues no further request.
- R12: A run with no miscompare and no timeout ends with `pass` and `done` high and the erase count equal to the budget. All result outputs hold until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle test start request |
| cfg_addr_scr | input | 1 | Select address scrambling |
| cfg_data_scr | input | 1 | Select data bit reversal |
| cfg_bg_en | input | 1 | Add the word-background passes |
| arr_req | output | 1 | Command pulse to the array |
| arr_op | output | 2 | Command code (erase, program, read) |
| arr_addr | output | AW | Physical word address |
| arr_wdata | output | W | Physical program data |
| arr_ready | input | 1 | Array idle / operation finished |
| arr_rdata | input | W | Physical read data |
| done | output | 1 | Test finished |
| pass | output | 1 | Test finished without failure |
| fail | output | 1 | Test stopped on a failure |
| fail_tmo | output | 1 | The failure was a timeout |
| fail_addr | output | AW | Logical address of the failure |
| fail_exp | output | W | Expected logical word |
| fail_got | output | W | Read logical word |
| fail_elem | output | EW | Element index of the failure |

## Verification
The assertions check on every cycle that each request lasts a single cycle and that a finished test shows exactly one verdict. They also check that the verdict and captured failure data stay frozen while no start arrives, that a timeout always shows as a failure, and that a passing run used exactly the erase budget. They further check that the address counter never steps past its last address. The exact command order, the address direction, the scrambling maps, the penalty spacing, the single program per erase, the capture of the first miscompare and the immunity to a start during a run are shown only by the bench's scenarios. The bench compares the issued command stream against an independently built expected stream while an array model with injected faults answers.

// File: rtl/fmbist_pkg.sv
package fmbist_pkg;

    // Command code on the array port
    typedef enum logic [1:0] {
        AOP_IDLE  = 2'b00,
        AOP_ERASE = 2'b01,
        AOP_PROG  = 2'b10,
        AOP_READ  = 2'b11
    } aop_e;

    // Per-address operation inside a march element
    typedef enum logic [2:0] {
        MOP_R1,
        MOP_W0,
        MOP_R0,
        MOP_WP,
        MOP_RP
    } mop_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_INIT,
        ST_ISSUE,
        ST_WAIT,
        ST_PEN,
        ST_ADV,
        ST_DONE
    } st_e;

    localparam int unsigned SOLID_ELEMS = 6;

endpackage

// File: rtl/fmbist_addr.sv
module fmbist_addr #(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          init,
    input  logic          step,
    input  logic          down,
    output logic [AW-1:0] addr,
    output logic          last
);

    logic [AW-1:0] addr_d, addr_q;
    logic          down_d, down_q;

    always_comb begin
        addr_d = addr_q;
        down_d = down_q;
        if (init) begin
            down_d = down;
            addr_d = down ? '1 : '0;
        end else if (step) begin
            addr_d = down_q ? addr_q - 1'b1 : addr_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            down_q <= 1'b0;
        end else begin
            addr_q <= addr_d;
            down_q <= down_d;
        end
    end

    assign addr = addr_q;
    assign last = down_q ? (addr_q == '0) : (addr_q == '1);

    // The sequencer must move to the next element instead of wrapping
    p_step_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> !last)
        else $error("address counter stepped past its end");

endmodule

// File: rtl/fmbist_timer.sv
module fmbist_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] val,
    output logic          zero
);

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/fmbist_ctrl.sv
module fmbist_ctrl
    import fmbist_pkg::*;
#(
    parameter int AW        = 10,
    parameter int W         = 8,
    parameter int EW        = $clog2(6 + 6 * $clog2(W) + 1),
    parameter int ERASE_TMO = 25_000_000,
    parameter int PROG_TMO  = 3000,
    parameter int READ_TMO  = 64,
    parameter int ERASE_PEN = 250_000,
    parameter int PROG_PEN  = 2100
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          cfg_addr_scr,
    input  logic          cfg_data_scr,
    input  logic          cfg_bg_en,
    output logic          arr_req,
    output logic [1:0]    arr_op,
    output logic [AW-1:0] arr_addr,
    output logic [W-1:0]  arr_wdata,
    input  logic          arr_ready,
    input  logic [W-1:0]  arr_rdata,
    output logic          done,
    output logic          pass,
    output logic          fail,
    output logic          fail_tmo,
    output logic [AW-1:0] fail_addr,
    output logic [W-1:0]  fail_exp,
    output logic [W-1:0]  fail_got,
    output logic [EW-1:0] fail_elem
);

    localparam int LOG2W = $clog2(W);
    localparam int KW    = (LOG2W > 1) ? $clog2(LOG2W) : 1;
    localparam int NELEM = 6 + 6 * LOG2W;
    localparam int TM1   = (ERASE_TMO > PROG_TMO) ? ERASE_TMO : PROG_TMO;
    localparam int TM2   = (TM1 > READ_TMO) ? TM1 : READ_TMO;
    localparam int TM3   = (TM2 > ERASE_PEN) ? TM2 : ERASE_PEN;
    localparam int TMAX  = (TM3 > PROG_PEN) ? TM3 : PROG_PEN;
    localparam int TW    = $clog2(TMAX + 1);

    typedef struct packed {
        st_e           st;
        logic [EW-1:0] elem;
        logic [1:0]    opi;
        logic          scr_a;
        logic          scr_d;
        logic          bg_en;
        logic          done;
        logic          pass;
        logic          fail;
        logic          tmo;
        logic [AW-1:0] faddr;
        logic [W-1:0]  fexp;
        logic [W-1:0]  fgot;
        logic [EW-1:0] felem;
    } regs_t;

    regs_t r_d, r_q;

    function automatic logic [W-1:0] bg_pattern(input logic [KW-1:0] k);
        logic [W-1:0] p;
        for (int i = 0; i < W; i++) p[i] = ~i[k];
        return p;
    endfunction

    function automatic logic [W-1:0] bit_rev(input logic [W-1:0] d);
        logic [W-1:0] o;
        for (int i = 0; i < W; i++) o[i] = d[W-1-i];
        return o;
    endfunction

    // Element decode
    logic          el_erase, el_down;
    logic [1:0]    el_nops;
    mop_e          cur_op;
    logic [KW-1:0] bg_k;
    logic          bg_inv;
    logic [EW-1:0] rel, pass_i, sub_i;

    always_comb begin
        el_erase = 1'b0;
        el_down  = 1'b0;
        el_nops  = 2'd1;
        cur_op   = MOP_R0;
        rel      = r_q.elem - EW'(SOLID_ELEMS);
        pass_i   = rel / EW'(3);
        sub_i    = rel % EW'(3);
        bg_k     = KW'(pass_i >> 1);
        bg_inv   = pass_i[0];
        if (r_q.elem < EW'(SOLID_ELEMS)) begin
            unique case (r_q.elem[2:0])
                3'd0, 3'd3: el_erase = 1'b1;
                3'd1, 3'd4: begin
                    el_down = (r_q.elem[2:0] == 3'd4);
                    el_nops = 2'd3;
                    cur_op  = (r_q.opi == 2'd0) ? MOP_R1 :
                              (r_q.opi == 2'd1) ? MOP_W0 : MOP_R0;
                end
                default: cur_op = MOP_R0;
            endcase
        end else begin
            el_erase = (sub_i == EW'(0));
            cur_op   = (sub_i == EW'(1)) ? MOP_WP : MOP_RP;
        end
    end

    // Operation data and array command
    logic [W-1:0]  pat, op_data, rd_log;
    logic [AW-1:0] a_log;
    logic          a_last, a_init, a_step;
    aop_e          cur_aop;
    logic          t_load, t_zero;
    logic [TW-1:0] t_val, tmo_val, pen_val;
    logic [EW-1:0] last_elem;

    always_comb begin
        pat = bg_pattern(bg_k) ^ {W{bg_inv}};
        unique case (cur_op)
            MOP_R1:         op_data = '1;
            MOP_W0, MOP_R0: op_data = '0;
            default:        op_data = pat;
        endcase
        if (el_erase)                                 cur_aop = AOP_ERASE;
        else if (cur_op == MOP_W0 || cur_op == MOP_WP) cur_aop = AOP_PROG;
        else                                          cur_aop = AOP_READ;
        unique case (cur_aop)
            AOP_ERASE: begin tmo_val = TW'(ERASE_TMO); pen_val = TW'(ERASE_PEN); end
            AOP_PROG:  begin tmo_val = TW'(PROG_TMO);  pen_val = TW'(PROG_PEN);  end
            default:   begin tmo_val = TW'(READ_TMO);  pen_val = '0;             end
        endcase
        rd_log    = r_q.scr_d ? bit_rev(arr_rdata) : arr_rdata;
        last_elem = r_q.bg_en ? EW'(NELEM - 1) : EW'(SOLID_ELEMS - 1);
    end

    assign arr_req   = (r_q.st == ST_ISSUE);
    assign arr_op    = arr_req ? cur_aop : AOP_IDLE;
    assign arr_addr  = el_erase ? '0 : (r_q.scr_a ? (a_log ^ (a_log >> 1)) : a_log);
    assign arr_wdata = r_q.scr_d ? bit_rev(op_data) : op_data;

    // Next-state
    always_comb begin
        r_d    = r_q;
        t_load = 1'b0;
        t_val  = tmo_val;
        a_init = 1'b0;
        a_step = 1'b0;
        unique case (r_q.st)
            ST_IDLE, ST_DONE: if (start) begin
                r_d       = '0;
                r_d.st    = ST_INIT;
                r_d.scr_a = cfg_addr_scr;
                r_d.scr_d = cfg_data_scr;
                r_d.bg_en = cfg_bg_en;
            end
            ST_INIT: begin
                a_init = 1'b1;
                r_d.st = ST_ISSUE;
            end
            ST_ISSUE: begin
                t_load = 1'b1;
                r_d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (arr_ready) begin
                    if (cur_aop == AOP_READ && rd_log != op_data) begin
                        r_d.st   = ST_DONE;
                        r_d.done = 1'b1;
                        r_d.fail = 1'b1;
                    end else if (cur_aop == AOP_READ) begin
                        r_d.st = ST_ADV;
                    end else begin
                        t_load = 1'b1;
                        t_val  = pen_val;
                        r_d.st = ST_PEN;
                    end
                end else if (t_zero) begin
                    r_d.st   = ST_DONE;
                    r_d.done = 1'b1;
                    r_d.fail = 1'b1;
                    r_d.tmo  = 1'b1;
                end
                if (r_d.fail) begin
                    r_d.faddr = a_log;
                    r_d.fexp  = op_data;
                    r_d.fgot  = rd_log;
                    r_d.felem = r_q.elem;
                end
            end
            ST_PEN: if (t_zero) r_d.st = ST_ADV;
            ST_ADV: begin
                if (!el_erase && (r_q.opi + 2'd1) < el_nops) begin
                    r_d.opi = r_q.opi + 2'd1;
                    r_d.st  = ST_ISSUE;
                end else if (el_erase || a_last) begin
                    r_d.opi = 2'd0;
                    if (r_q.elem == last_elem) begin
                        r_d.st   = ST_DONE;
                        r_d.done = 1'b1;
                        r_d.pass = 1'b1;
                    end else begin
                        r_d.elem = r_q.elem + 1'b1;
                        r_d.st   = ST_INIT;
                    end
                end else begin
                    a_step  = 1'b1;
                    r_d.opi = 2'd0;
                    r_d.st  = ST_ISSUE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    fmbist_addr #(.AW(AW)) i_addr (
        .clk   (clk),
        .rst_n (rst_n),
        .init  (a_init),
        .step  (a_step),
        .down  (el_down),
        .addr  (a_log),
        .last  (a_last)
    );

    fmbist_timer #(.TW(TW)) i_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (t_load),
        .val   (t_val),
        .zero  (t_zero)
    );

    assign done      = r_q.done;
    assign pass      = r_q.pass;
    assign fail      = r_q.fail;
    assign fail_tmo  = r_q.tmo;
    assign fail_addr = r_q.faddr;
    assign fail_exp  = r_q.fexp;
    assign fail_got  = r_q.fgot;
    assign fail_elem = r_q.felem;

    // Erase counter kept only for the budget property
    logic [7:0] ers_cnt_q;
    always_ff @(posedge clk) begin
        if (!rst_n || ((r_q.st == ST_IDLE || r_q.st == ST_DONE) && start)) ers_cnt_q <= '0;
        else if (arr_req && arr_op == AOP_ERASE)                             ers_cnt_q <= ers_cnt_q + 1'b1;
    end

    p_req_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        arr_req |=> !arr_req)
        else $error("request lasted more than one cycle");

    p_one_verdict_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (pass ^ fail))
        else $error("finished without exactly one verdict");

    p_hold_result_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_DONE && !start) |=> $stable({done, pass, fail, fail_tmo, fail_addr,
                                                    fail_exp, fail_got, fail_elem}))
        else $error("result changed without a start");

    p_tmo_is_fail_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fail_tmo |-> (fail && done))
        else $error("timeout flag without failure");

    p_erase_budget_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && pass) |-> (ers_cnt_q == (r_q.bg_en ? 8'(2 + 2 * LOG2W) : 8'd2)))
        else $error("erase count differs from budget");

endmodule

// File: tb/test_fmbist_ctrl.sv
module test_fmbist_ctrl;

    localparam int AW    = 3;
    localparam int W     = 4;
    localparam int N     = 1 << AW;
    localparam int LOG2W = 2;
    localparam int EW    = $clog2(6 + 6 * LOG2W + 1);
    localparam int EPEN  = 6;
    localparam int PPEN  = 5;
    localparam int ELAT  = 4;
    localparam int PLAT  = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          cfg_addr_scr = 1'b0, cfg_data_scr = 1'b0, cfg_bg_en = 1'b0;
    logic          arr_req;
    logic [1:0]    arr_op;
    logic [AW-1:0] arr_addr;
    logic [W-1:0]  arr_wdata;
    logic          arr_ready;
    logic [W-1:0]  arr_rdata;
    logic          done, pass, fail, fail_tmo;
    logic [AW-1:0] fail_addr;
    logic [W-1:0]  fail_exp, fail_got;
    logic [EW-1:0] fail_elem;

    always #5 clk = ~clk;

    fmbist_ctrl #(
        .AW(AW), .W(W), .ERASE_TMO(40), .PROG_TMO(20), .READ_TMO(10),
        .ERASE_PEN(EPEN), .PROG_PEN(PPEN)
    ) i_fmbist_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_addr_scr(cfg_addr_scr), .cfg_data_scr(cfg_data_scr), .cfg_bg_en(cfg_bg_en),
        .arr_req(arr_req), .arr_op(arr_op), .arr_addr(arr_addr), .arr_wdata(arr_wdata),
        .arr_ready(arr_ready), .arr_rdata(arr_rdata),
        .done(done), .pass(pass), .fail(fail), .fail_tmo(fail_tmo),
        .fail_addr(fail_addr), .fail_exp(fail_exp), .fail_got(fail_got), .fail_elem(fail_elem)
    );

    int tests = 0, fails = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    // ---------------- array model with fault injection ----------------
    logic [W-1:0]  mem [N];
    bit            progd [N];
    bit            stuck_en = 0, bridge_en = 0, hang_en = 0;
    logic [AW-1:0] stuck_addr = '0, bridge_addr = '0;
    int            stuck_bit = 0;
    int            lat_cnt;
    int            prog_twice = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            arr_ready <= 1'b1;
            arr_rdata <= '0;
            lat_cnt   <= 0;
            for (int i = 0; i < N; i++) begin mem[i] <= '1; progd[i] <= 0; end
        end else if (arr_req) begin
            arr_ready <= 1'b0;
            if (arr_op == 2'b01) begin
                lat_cnt <= ELAT;
                for (int i = 0; i < N; i++) begin mem[i] <= '1; progd[i] <= 0; end
            end else if (arr_op == 2'b10) begin
                lat_cnt <= PLAT;
                if (progd[arr_addr]) prog_twice <= prog_twice + 1;
                progd[arr_addr] <= 1;
                mem[arr_addr]   <= mem[arr_addr] & arr_wdata;
            end else begin
                logic [W-1:0] v;
                lat_cnt <= 1;
                v = mem[arr_addr];
                if (stuck_en && arr_addr == stuck_addr) v[stuck_bit] = 1'b0;
                if (bridge_en && arr_addr == bridge_addr) begin
                    v[0] = v[0] & v[1];
                    v[1] = v[0];
                end
                arr_rdata <= v;
            end
        end else if (lat_cnt != 0) begin
            lat_cnt <= lat_cnt - 1;
            if (lat_cnt == 1 && !hang_en) arr_ready <= 1'b1;
        end
    end

    // ---------------- scoreboard ----------------
    typedef struct {
        logic [1:0]    op;
        logic [AW-1:0] addr;
        logic [W-1:0]  data;
    } cmd_t;

    cmd_t          expq[$];
    logic [AW-1:0] prog_addrs[$];
    int            stream_err = 0, n_erase = 0, n_prog = 0, n_read = 0;
    int            pulse_err = 0, pen_err = 0, req_total = 0;
    int            cyc = 0, stamp = 0, pen_need = 0;
    bit            prev_req = 0, prev_ready = 1;
    logic [1:0]    last_op = 2'b00;

    function automatic logic [W-1:0] rev_w(input logic [W-1:0] d);
        logic [W-1:0] o;
        for (int i = 0; i < W; i++) o[i] = d[W-1-i];
        return o;
    endfunction

    task automatic push(input logic [1:0] op, input int la, input logic [W-1:0] ld, input bit sa, input bit sd);
        cmd_t c;
        logic [AW-1:0] a;
        a      = AW'(la);
        c.op   = op;
        c.addr = (op == 2'b01) ? '0 : (sa ? (a ^ (a >> 1)) : a);
        c.data = (op == 2'b10) ? (sd ? rev_w(ld) : ld) : '0;
        expq.push_back(c);
    endtask

    task automatic build_expected(input bit bg, input bit sa, input bit sd);
        expq.delete();
        push(2'b01, 0, '0, sa, sd);
        for (int a = 0; a < N; a++) begin
            push(2'b11, a, '0, sa, sd); push(2'b10, a, '0, sa, sd); push(2'b11, a, '0, sa, sd);
        end
        for (int a = 0; a < N; a++) push(2'b11, a, '0, sa, sd);
        push(2'b01, 0, '0, sa, sd);
        for (int a = N - 1; a >= 0; a--) begin
            push(2'b11, a, '0, sa, sd); push(2'b10, a, '0, sa, sd); push(2'b11, a, '0, sa, sd);
        end
        for (int a = 0; a < N; a++) push(2'b11, a, '0, sa, sd);
        if (bg) begin
            for (int k = 0; k < LOG2W; k++) begin
                for (int inv = 0; inv < 2; inv++) begin
                    logic [W-1:0] p;
                    for (int i = 0; i < W; i++) p[i] = (((i >> k) & 1) == 0) ^ (inv == 1);
                    push(2'b01, 0, '0, sa, sd);
                    for (int a = 0; a < N; a++) push(2'b10, a, p, sa, sd);
                    for (int a = 0; a < N; a++) push(2'b11, a, '0, sa, sd);
                end
            end
        end
    endtask

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (rst_n) begin
            if (arr_req && prev_req) pulse_err <= pulse_err + 1;
            if (arr_ready && !prev_ready && (last_op == 2'b01 || last_op == 2'b10)) begin
                stamp    <= cyc;
                pen_need <= (last_op == 2'b01) ? EPEN : PPEN;
            end
            if (arr_req) begin
                req_total <= req_total + 1;
                if (pen_need != 0 && cyc - stamp < pen_need) pen_err <= pen_err + 1;
                pen_need <= 0;
                last_op  <= arr_op;
                if (arr_op == 2'b01) n_erase <= n_erase + 1;
                if (arr_op == 2'b10) begin n_prog <= n_prog + 1; prog_addrs.push_back(arr_addr); end
                if (arr_op == 2'b11) n_read <= n_read + 1;
                if (expq.size() == 0) begin
                    stream_err <= stream_err + 1;
                    $display("stream: unexpected op %0b addr %0h", arr_op, arr_addr);
                end else begin
                    cmd_t e;
                    e = expq.pop_front();
                    if (e.op != arr_op || e.addr != arr_addr || (arr_op == 2'b10 && e.data != arr_wdata)) begin
                        stream_err <= stream_err + 1;
                        $display("stream: op %0b addr %0h data %0h, wanted %0b %0h %0h",
                                 arr_op, arr_addr, arr_wdata, e.op, e.addr, e.data);
                    end
                end
            end
        end
        prev_req   <= arr_req;
        prev_ready <= arr_ready;
    end

    task automatic launch(input bit bg, input bit sa, input bit sd);
        cfg_bg_en = bg; cfg_addr_scr = sa; cfg_data_scr = sd;
        build_expected(bg, sa, sd);
        @(negedge clk);
        stream_err = 0; n_erase = 0; n_prog = 0; n_read = 0; pen_err = 0;
        prog_twice = 0; prog_addrs.delete();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        while (!done) @(negedge clk);
        @(negedge clk);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (100000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: got hung expected done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // ---------------- scenarios ----------------
    initial begin
        int snap;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(done == 0 && pass == 0 && fail == 0, "R1", "reset outputs", {done, pass, fail}, 0);
        check(arr_req == 0, "R1", "no request after reset", arr_req, 0);

        // Plain bit-oriented run with a start pulse mid-run
        launch(0, 0, 0);
        repeat (30) @(negedge clk);
        start = 1'b1; @(negedge clk); start = 1'b0;
        wait_done();
        check(stream_err == 0 && expq.size() == 0, "R3", "solid stream errors", stream_err, 0);
        check(stream_err == 0, "R1", "start while running ignored", stream_err, 0);
        check(pulse_err == 0, "R2", "request pulse width errors", pulse_err, 0);
        check(n_erase == 2 && n_prog == 2 * N && n_read == 6 * N, "R3", "erase/prog/read budget",
              {8'(n_erase), 8'(n_prog), 8'(n_read)}, {8'd2, 8'(2 * N), 8'(6 * N)});
        check(prog_addrs[N] == AW'(N - 1) && prog_addrs[2*N-1] == '0, "R4", "descending ends",
              {prog_addrs[N], prog_addrs[2*N-1]}, {AW'(N - 1), AW'(0)});
        check(pen_err == 0, "R10", "penalty violations", pen_err, 0);
        check(prog_twice == 0, "R6", "double programs", prog_twice, 0);
        check(pass == 1 && fail == 0, "R12", "clean verdict", {pass, fail}, 2'b10);
        snap = req_total;
        repeat (20) @(negedge clk);
        check(pass == 1 && done == 1 && req_total == snap, "R12", "result holds, no requests",
              req_total, snap);

        // Address scrambling only
        launch(0, 1, 0);
        wait_done();
        check(stream_err == 0 && expq.size() == 0, "R7", "address scramble stream", stream_err, 0);
        check(pass == 1, "R7", "pass with address scramble", pass, 1);

        // Data scrambling with backgrounds
        launch(1, 0, 1);
        wait_done();
        check(stream_err == 0 && expq.size() == 0, "R8", "data scramble stream", stream_err, 0);
        check(n_erase == 6 && n_prog == 6 * N && n_read == 10 * N, "R5", "background budget",
              {8'(n_erase), 8'(n_prog), 8'(n_read)}, {8'd6, 8'(6 * N), 8'(10 * N)});
        check(prog_twice == 0 && pen_err == 0, "R6", "background programs once, penalties kept",
              prog_twice + pen_err, 0);

        // Both scramblings with backgrounds
        launch(1, 1, 1);
        wait_done();
        check(stream_err == 0 && expq.size() == 0 && pass == 1, "R5", "full stream both scrambles",
              stream_err, 0);

        // Stuck-at-0 on bit 2 of word 5
        stuck_en = 1; stuck_addr = 3'd5; stuck_bit = 2;
        launch(0, 0, 0);
        wait_done();
        check(fail == 1 && pass == 0 && fail_tmo == 0, "R11", "stuck-at verdict", {fail, pass, fail_tmo}, 3'b100);
        check(fail_addr == 3'd5 && fail_elem == EW'(1), "R11", "stuck-at location",
              {fail_addr, fail_elem}, {3'd5, EW'(1)});
        check(fail_exp == 4'hF && fail_got == 4'hB, "R11", "stuck-at data", {fail_exp, fail_got}, 8'hFB);
        check(stream_err == 0, "R11", "prefix before failure", stream_err, 0);
        snap = req_total;
        repeat (20) @(negedge clk);
        check(req_total == snap && fail == 1, "R11", "no request after failure", req_total, snap);
        stuck_en = 0;

        // Bit bridge seen only by a background
        bridge_en = 1; bridge_addr = 3'd3;
        launch(1, 0, 0);
        wait_done();
        check(fail == 1 && fail_elem == EW'(8) && fail_addr == 3'd3, "R5", "bridge caught by pattern pass",
              {fail_elem, fail_addr}, {EW'(8), 3'd3});
        check(fail_exp == 4'h5 && fail_got == 4'h4, "R11", "bridge data", {fail_exp, fail_got}, 8'h54);
        bridge_en = 0;

        // Array never finishes the first erase
        hang_en = 1;
        launch(0, 0, 0);
        wait_done();
        check(fail == 1 && fail_tmo == 1 && fail_elem == EW'(0), "R9", "timeout report",
              {fail, fail_tmo, fail_elem}, {2'b11, EW'(0)});
        hang_en = 0;

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule